// File: doc/BRIEF.md
# Sequential-Run Wait-State Memory Controller

This block sits between a 32-bit processor bus and a slow DRAM-style memory. For every bus cycle it decides how many wait states to insert. It also decides which of two termination signals ends the cycle: a short synchronous acknowledge or a longer asynchronous acknowledge. On the processor side, a synchronous cycle completes in four timing states and an asynchronous cycle in six. At a 16 MHz clock these come to 125 ns and 187.5 ns.

The controller remembers the address and direction of the last completed access. An access that opens a run pays the full first-access wait count and ends asynchronously. An access that continues the run uses a separate, shorter wait count. It stays on the same word stride, keeps the same direction and arrives after only a short idle gap. When that shorter count is zero, the access ends with the synchronous acknowledge. Any break in the pattern makes the next access pay the full latency again.

Top module: `seqwait_memctl`

## Requirements
- R1: While reset is held, and at the first sample after it is released, `term_sync`, `term_async` and `mem_en` are low. The first access after reset always takes the full first-access latency and ends asynchronously, whatever its address, including address 4.
- R2: For a run-opening access with `mem_ready` high, the termination appears after the (N+2)-th rising edge, counting the edge that samples `cpu_strobe` high as the first. N is `cfg_first_ws`. The termination is `term_async`.
- R3: An access continues a run when three conditions all hold. Its address equals the previous completed address plus 4, modulo 2^32. `cpu_write` matches the previous access. The idle count since that access is not above `cfg_idle_limit`. Such an access uses N = `cfg_seq_ws` with the same latency formula as R2.
- R4: A run-continuing access ends with `term_sync` when `cfg_seq_ws` is 0, and with `term_async` otherwise. A run-opening access never ends with `term_sync`.
- R5: An address other than previous plus 4 ends the run, including a repeat of the same address or a backward step. The access pays the full first-access latency.
- R6: A change of `cpu_write` ends the run. The following same-direction +4 access continues the new run.
- R7: The idle count is the number of rising edges after the termination is released at which the controller is idle and `cpu_strobe` is low. A count greater than `cfg_idle_limit` ends the run.
- R8: `mem_en` is high from the edge that accepts the strobe until the termination is raised, and never together with a termination. After the wait count expires, each edge that samples `mem_ready` low delays the termination by one cycle.
- R9: At most one termination is high at a time. It stays unchanged while `cpu_strobe` remains high. It clears at the first edge that samples `cpu_strobe` low.
- R10: Address 0x00000000 following 0xFFFFFFFC in the same direction counts as run-continuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_strobe | input | 1 | Processor bus-cycle strobe, active high |
| cpu_addr | input | 32 | Byte address of the bus cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cfg_first_ws | input | 3 | Wait states for a run-opening access |
| cfg_seq_ws | input | 3 | Wait states for a run-continuing access; 0 selects the synchronous acknowledge |
| cfg_idle_limit | input | 4 | Largest idle count that keeps a run alive |
| term_sync | output | 1 | Synchronous cycle acknowledge |
| term_async | output | 1 | Asynchronous cycle acknowledge |
| mem_en | output | 1 | Memory access enable |
| mem_ready | input | 1 | Memory data ready |

## Verification
A corrupted stored address, direction or valid flag changes the wait count on the very next access. It shows at the ports as a termination that arrives early or late by the difference between the two configured counts, or as the wrong acknowledge. A stuck idle counter only shows when an access follows a gap near the limit, so gaps on both sides of the limit are swept. A wait counter that is off by one shifts every latency by one cycle and is caught on the first access of any sweep.

// File: rtl/seqwait_pkg.sv
package seqwait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TERM = 2'd2
  } ctl_state_t;

  typedef enum logic {
    TK_ASYNC = 1'b0,
    TK_SYNC  = 1'b1
  } term_kind_t;

  // Short acknowledge only for a run continuation with zero wait states
  function automatic term_kind_t pick_term(input logic run_hit, input logic ws_zero);
    return (run_hit && ws_zero) ? TK_SYNC : TK_ASYNC;
  endfunction

endpackage

// File: rtl/seqwait_run_tracker.sv
module seqwait_run_tracker #(
  parameter int ADDR_W = 32,
  parameter int IDLE_W = 4,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_idle,
  input  logic              cpu_strobe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_write,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              retire,
  input  logic [ADDR_W-1:0] retire_addr,
  input  logic              retire_write,
  output logic              run_hit
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] last_addr;
  logic              last_write;
  logic              last_valid;
  logic [IDLE_W-1:0] idle_cnt;

  function automatic logic [ADDR_W-1:0] follow_addr(input logic [ADDR_W-1:0] a);
    return a + STEP;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr  <= '0;
      last_write <= 1'b0;
      last_valid <= 1'b0;
      idle_cnt   <= '0;
    end else if (retire) begin
      last_addr  <= retire_addr;
      last_write <= retire_write;
      last_valid <= 1'b1;
      idle_cnt   <= '0;
    end else if (in_idle && !cpu_strobe && idle_cnt != '1) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign run_hit = last_valid
                && (cpu_addr == follow_addr(last_addr))
                && (cpu_write == last_write)
                && (idle_cnt <= idle_limit);

endmodule

// File: rtl/seqwait_wait_timer.sv
module seqwait_wait_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            run,
  output logic            expired
);
  logic [WS_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                   remain <= '0;
    else if (load)                remain <= load_val;
    else if (run && remain != '0) remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/seqwait_memctl.sv
module seqwait_memctl #(
  parameter int ADDR_W = 32,
  parameter int WS_W   = 3,
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strobe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_write,
  input  logic [WS_W-1:0]   cfg_first_ws,
  input  logic [WS_W-1:0]   cfg_seq_ws,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  output logic              term_sync,
  output logic              term_async,
  output logic              mem_en,
  input  logic              mem_ready
);
  import seqwait_pkg::*;

  ctl_state_t        state;
  term_kind_t        kind;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;

  // Named internal events
  logic            start;
  logic            retire;
  logic            run_hit;
  logic            wait_done;
  logic [WS_W-1:0] ws_sel;

  assign start  = (state == ST_IDLE) && cpu_strobe;
  assign retire = (state == ST_TERM) && !cpu_strobe;
  assign ws_sel = run_hit ? cfg_seq_ws : cfg_first_ws;

  seqwait_run_tracker #(.ADDR_W(ADDR_W), .IDLE_W(IDLE_W), .STRIDE(4)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_idle      (state == ST_IDLE),
    .cpu_strobe   (cpu_strobe),
    .cpu_addr     (cpu_addr),
    .cpu_write    (cpu_write),
    .idle_limit   (cfg_idle_limit),
    .retire       (retire),
    .retire_addr  (cur_addr),
    .retire_write (cur_write),
    .run_hit      (run_hit)
  );

  seqwait_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (ws_sel),
    .run      (state == ST_WAIT),
    .expired  (wait_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= TK_ASYNC;
      cur_addr  <= '0;
      cur_write <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_WAIT;
          cur_addr  <= cpu_addr;
          cur_write <= cpu_write;
          kind      <= pick_term(run_hit, cfg_seq_ws == '0);
        end
        ST_WAIT: if (wait_done && mem_ready) state <= ST_TERM;
        ST_TERM: if (!cpu_strobe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_en     = (state == ST_WAIT);
  assign term_sync  = (state == ST_TERM) && (kind == TK_SYNC);
  assign term_async = (state == ST_TERM) && (kind == TK_ASYNC);

endmodule

// File: rtl/seqwait_memctl_chk.sv
module seqwait_memctl_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_strobe,
  input logic mem_ready,
  input logic mem_en,
  input logic term_sync,
  input logic term_async,
  input logic start
);
  logic term_any;
  assign term_any = term_sync || term_async;

  AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    !(term_sync && term_async)); // R9

  AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    term_any && cpu_strobe |=> $stable(term_sync) && $stable(term_async)); // R9

  AST_TERM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    term_any && !cpu_strobe |=> !term_any); // R9

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && term_any)); // R8

  AST_EN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_en); // R8

  AST_TERM_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_any) |-> $past(mem_en) && $past(mem_ready)); // R8

endmodule

bind seqwait_memctl seqwait_memctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_strobe (cpu_strobe),
  .mem_ready  (mem_ready),
  .mem_en     (mem_en),
  .term_sync  (term_sync),
  .term_async (term_async),
  .start      (start)
);

// File: tb/test_seqwait_memctl.sv
module test_seqwait_memctl;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_strobe = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_write = 1'b0;
  logic [2:0]  cfg_first_ws = 3'd0;
  logic [2:0]  cfg_seq_ws = 3'd0;
  logic [3:0]  cfg_idle_limit = 4'(LIMIT);
  logic        term_sync, term_async, mem_en;
  logic        mem_ready = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqwait_memctl i_seqwait_memctl (
    .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .cpu_addr(cpu_addr),
    .cpu_write(cpu_write), .cfg_first_ws(cfg_first_ws), .cfg_seq_ws(cfg_seq_ws),
    .cfg_idle_limit(cfg_idle_limit), .term_sync(term_sync), .term_async(term_async),
    .mem_en(mem_en), .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One bus cycle: idle gap, strobe, count edges until a termination, check hold and release
  task automatic access(input logic [31:0] a, input bit w, input int gap, input int extra,
                        input int exp_lat, input bit exp_sync, input string req);
    int cnt = 0;
    repeat (gap) @(posedge clk);
    @(negedge clk);
    cpu_addr = a; cpu_write = w; cpu_strobe = 1'b1;
    while (!(term_sync || term_async) && cnt < 40) begin
      mem_ready = (extra == 0) || (cnt >= exp_lat - 1);
      @(posedge clk); #1;
      cnt++;
      if (cnt == 1) chk(mem_en == 1'b1, "R8", "mem_en after strobe", int'(mem_en), 1);
    end
    mem_ready = 1'b1;
    chk(cnt == exp_lat, req, "latency", cnt, exp_lat);
    chk(term_sync == exp_sync && term_async == !exp_sync, req, "sync ack",
        int'(term_sync), int'(exp_sync));
    @(posedge clk); #1;
    chk((term_sync || term_async) && !mem_en, "R9", "held", int'(term_sync || term_async), 1);
    @(negedge clk); cpu_strobe = 1'b0;
    @(posedge clk); #1;
    chk(!term_sync && !term_async, "R9", "released", int'(term_sync || term_async), 0);
  endtask

  initial begin
    logic [31:0] b;
    repeat (3) @(posedge clk);
    #1;
    chk(!term_sync && !term_async && !mem_en, "R1", "reset outputs", int'(mem_en), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!term_sync && !term_async && !mem_en, "R1", "after reset", int'(mem_en), 0);

    // R1: address 4 right after reset is still run-opening
    cfg_first_ws = 3'd4; cfg_seq_ws = 3'd0;
    access(32'h4, 1'b0, 0, 0, 6, 1'b0, "R1");

    // R2/R3/R4 sweep over all wait configurations
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 8; s++) begin
        cfg_first_ws = 3'(f); cfg_seq_ws = 3'(s);
        b = 32'h1000 + 32'((f*8 + s) * 64);
        access(b,     1'b0, 0, 0, f + 2, 1'b0,   "R2");
        access(b + 4, 1'b0, 0, 0, s + 2, s == 0, "R3");
        access(b + 8, 1'b0, 1, 0, s + 2, s == 0, "R4");
      end
    end

    cfg_first_ws = 3'd5; cfg_seq_ws = 3'd1;
    // R6: direction change restarts the run
    access(32'h8000, 1'b0, 0, 0, 7, 1'b0, "R6");
    access(32'h8004, 1'b1, 0, 0, 7, 1'b0, "R6");
    access(32'h8008, 1'b1, 0, 0, 3, 1'b0, "R6");
    // R5: skip, repeat, backward step
    access(32'h8010, 1'b1, 0, 0, 7, 1'b0, "R5");
    access(32'h8010, 1'b1, 0, 0, 7, 1'b0, "R5");
    access(32'h800C, 1'b1, 0, 0, 7, 1'b0, "R5");

    // R7: idle gaps around the limit
    cfg_seq_ws = 3'd0;
    for (int g = 0; g <= LIMIT + 3; g++) begin
      b = 32'h9000 + 32'(g * 32);
      access(b,     1'b0, 0, 0, 7, 1'b0, "R7");
      access(b + 4, 1'b0, g, 0, (g <= LIMIT) ? 2 : 7, g <= LIMIT, "R7");
    end

    // R10: wrap of the address space
    access(32'hFFFF_FFFC, 1'b1, 0, 0, 7, 1'b0, "R10");
    access(32'h0000_0000, 1'b1, 0, 0, 2, 1'b1, "R10");

    // R8: memory not ready stretches the cycle
    cfg_first_ws = 3'd2;
    for (int k = 1; k <= 3; k++) begin
      b = 32'hA000 + 32'(k * 64);
      access(b,     1'b0, 0, k, 2 + k + 2, 1'b0, "R8");
      access(b + 4, 1'b0, 0, k, 0 + k + 2, 1'b1, "R8");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule